// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects up to `N_IRQ` interrupt request lines and decides which one the processor should service next. Each request line leaves two records. The latched record captures every raise, whether or not the line is enabled. The visible status record captures a raise only when the line's enable bit is set. If a line is enabled after its request has already been latched, the request moves into the visible status at once and the processor is woken. Each line has its own `PRIO_W`-bit priority, where 0 is the most urgent. A ceiling register holds the priority of the handler that is running now. A global lock stops the processor from being woken or given a winner.

Software drives the block through one command port. A command is a valid strobe, an opcode, a line index and a data word. The opcodes cover enable, disable, clear of one line, clear of all lines, clear of enabled lines only, priority write, ceiling write and lock write. The winner index and its valid flag are decoded combinationally from registered state. The wake output is a registered pulse. It follows one cycle after the raise or command that causes it.

Top module: `irqc_top`

## Requirements
- R1: Synchronous reset (`rst` high) clears the enable mask, the latched record, the status record, the lock and `cpu_wake`, sets every line priority to 255 and sets the ceiling to 256 (idle), so that `win_valid` is low.
- R2: With `cmd_valid` high, `cmd_op` selects the operation: 0 enable line `cmd_idx`, 1 disable it, 2 clear it, 3 clear all, 4 clear enabled, 5 write priority `cmd_data[7:0]` to line `cmd_idx`, 6 write ceiling `cmd_data[8:0]`, 7 write lock `cmd_data[0]`.
- R3: A high bit of `irq_raise` always sets that line's latched bit. It sets the status bit only if the line was enabled before that clock edge.
- R4: Enabling a line whose latched bit is set also sets its status bit. If the block is unlocked, `cpu_wake` pulses in the next cycle.
- R5: Disable clears only the mask bit. The status and latched bits of that line are kept.
- R6: Clearing a line removes both its status bit and its latched bit. A raise of the same line in the same cycle wins over the clear.
- R7: Clear-all empties both records. Clear-enabled empties the status record and removes latched bits only on enabled lines.
- R8: The winner is the status line with the smallest priority value, and that value must be strictly below the ceiling. A ceiling of 256 lets any priority win.
- R9: Among status lines with equal priority, the lower index wins.
- R10: While locked, `win_valid` is low and plain raises or enables do not wake. A lock write from 1 to 0 while the status record is nonzero pulses `cpu_wake` next cycle. If the status record is empty, no pulse follows.
- R11: Any raise while unlocked pulses `cpu_wake` in the next cycle, even when the raised line is masked.
- R12: `hard_raise` pulses `cpu_wake` in the next cycle even while locked. It bypasses the lock only for that request and leaves the lock set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raise | input | N_IRQ | Per-line raise pulses |
| hard_raise | input | 1 | Request that bypasses the lock once |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode (see R2) |
| cmd_idx | input | IDX_W | Line addressed by the command |
| cmd_data | input | PRIO_W+1 | Priority, ceiling or lock value |
| cpu_wake | output | 1 | Registered wake pulse |
| win_valid | output | 1 | A winner exists |
| win_idx | output | IDX_W | Index of the winning line |
| status_out | output | N_IRQ | Status record |
| mask_out | output | N_IRQ | Enable mask |

## Verification
The bench builds the block with `N_IRQ` = 8 and `PRIO_W` = 8. With these values the whole status and mask fit in one byte that a vector can state, while the priority compare and the 256-valued idle ceiling keep their full width. Eight lines are enough for equal-priority ties, lines held masked behind enabled ones, and a line that is latched while disabled and enabled later. One short table can then walk a run in which enable, clear, lock and ceiling writes interleave with raises.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    OP_ENABLE   = 3'd0,
    OP_DISABLE  = 3'd1,
    OP_CLR_ONE  = 3'd2,
    OP_CLR_ALL  = 3'd3,
    OP_CLR_EN   = 3'd4,
    OP_SET_PRIO = 3'd5,
    OP_SET_CEIL = 3'd6,
    OP_SET_LOCK = 3'd7
  } irqc_op_e;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
#(
  parameter int N_IRQ = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] raise,
  input  logic             op_valid,
  input  irqc_op_e         op,
  input  logic [IDX_W-1:0] idx,
  output logic [N_IRQ-1:0] mask_q,
  output logic [N_IRQ-1:0] latched_q,
  output logic [N_IRQ-1:0] status_q,
  output logic             relatch
);
  logic [N_IRQ-1:0] sel, mask_n, lat_n, st_n;

  assign sel = {{(N_IRQ-1){1'b0}}, 1'b1} << idx;

  always_comb begin
    mask_n  = mask_q;
    lat_n   = latched_q;
    st_n    = status_q;
    relatch = 1'b0;
    if (op_valid) begin
      case (op)
        OP_ENABLE: begin
          mask_n = mask_q | sel;
          if ((latched_q & sel) != '0) begin
            st_n    = st_n | sel;
            relatch = 1'b1;
          end
        end
        OP_DISABLE: mask_n = mask_q & ~sel;
        OP_CLR_ONE: begin
          st_n  = st_n & ~sel;
          lat_n = lat_n & ~sel;
        end
        OP_CLR_ALL: begin
          st_n  = '0;
          lat_n = '0;
        end
        OP_CLR_EN: begin
          st_n  = '0;
          lat_n = latched_q & ~mask_q;
        end
        default: ;
      endcase
    end
    // raises applied last so they override a same-cycle clear
    lat_n = lat_n | raise;
    st_n  = st_n | (raise & mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      latched_q <= '0;
      status_q  <= '0;
    end else begin
      mask_q    <= mask_n;
      latched_q <= lat_n;
      status_q  <= st_n;
    end
  end
endmodule

// File: rtl/irqc_prio_regs.sv
module irqc_prio_regs #(
  parameter int N_IRQ  = 64,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        widx,
  input  logic [PRIO_W-1:0]       wdata,
  output logic [N_IRQ*PRIO_W-1:0] prio_flat
);
  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    logic [PRIO_W-1:0] level_q;
    always_ff @(posedge clk) begin
      if (rst)                                level_q <= '1;
      else if (we && (widx == IDX_W'(g)))     level_q <= wdata;
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = level_q;
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N_IRQ  = 64,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic [N_IRQ-1:0]        pend,
  input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W:0]         ceiling,
  input  logic                    block,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  logic [PRIO_W:0]  best;
  logic             found;
  logic [IDX_W-1:0] pick;

  always_comb begin
    best  = ceiling;
    found = 1'b0;
    pick  = '0;
    // strict compare: an equal value at a higher index never displaces
    for (int i = 0; i < N_IRQ; i++) begin
      if (pend[i] && ({1'b0, prio_flat[i*PRIO_W +: PRIO_W]} < best)) begin
        best  = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]};
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
    hit = found && !block;
    idx = hit ? pick : '0;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_IRQ  = 64,
  parameter int PRIO_W = 8,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IRQ-1:0]  irq_raise,
  input  logic              hard_raise,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [PRIO_W:0]   cmd_data,
  output logic              cpu_wake,
  output logic              win_valid,
  output logic [IDX_W-1:0]  win_idx,
  output logic [N_IRQ-1:0]  status_out,
  output logic [N_IRQ-1:0]  mask_out
);
  localparam logic [PRIO_W:0] CEIL_IDLE = {1'b1, {PRIO_W{1'b0}}};

  irqc_op_e                op;
  logic [N_IRQ-1:0]        latched_q;
  logic                    relatch;
  logic [N_IRQ*PRIO_W-1:0] prio_flat;
  logic                    lock_q;
  logic [PRIO_W:0]         cur_q;
  logic                    wake_d;
  logic                    unlock_hit;

  assign op = irqc_op_e'(cmd_op);

  irqc_pending #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst(rst), .raise(irq_raise),
    .op_valid(cmd_valid), .op(op), .idx(cmd_idx),
    .mask_q(mask_out), .latched_q(latched_q), .status_q(status_out),
    .relatch(relatch)
  );

  irqc_prio_regs #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst(rst),
    .we(cmd_valid && (op == OP_SET_PRIO)),
    .widx(cmd_idx), .wdata(cmd_data[PRIO_W-1:0]),
    .prio_flat(prio_flat)
  );

  irqc_arbiter #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .pend(status_out), .prio_flat(prio_flat), .ceiling(cur_q),
    .block(lock_q), .hit(win_valid), .idx(win_idx)
  );

  assign unlock_hit = cmd_valid && (op == OP_SET_LOCK) && lock_q
                      && !cmd_data[0] && (status_out != '0);

  assign wake_d = hard_raise
                || ((irq_raise != '0) && !lock_q)
                || (relatch && !lock_q)
                || unlock_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 1'b0;
      cur_q    <= CEIL_IDLE;
      cpu_wake <= 1'b0;
    end else begin
      cpu_wake <= wake_d;
      if (cmd_valid && (op == OP_SET_LOCK)) lock_q <= cmd_data[0];
      if (cmd_valid && (op == OP_SET_CEIL)) cur_q  <= cmd_data;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N_IRQ  = 64,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic [N_IRQ-1:0]        irq_raise,
  input logic                    hard_raise,
  input logic                    cmd_valid,
  input logic [2:0]              cmd_op,
  input logic                    cpu_wake,
  input logic                    win_valid,
  input logic [IDX_W-1:0]        win_idx,
  input logic [N_IRQ-1:0]        status_out,
  input logic [N_IRQ-1:0]        mask_out,
  input logic                    lock_q,
  input logic [PRIO_W:0]         cur_q,
  input logic [N_IRQ*PRIO_W-1:0] prio_flat
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask_out == '0 && status_out == '0 && !cpu_wake
                    && !win_valid && !lock_q && cur_q == {1'b1, {PRIO_W{1'b0}}}));

  a_r3_masked_no_status: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ((status_out & ~$past(status_out) & ~$past(mask_out)) == '0));

  a_r5_disable_keeps: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1) |=>
      (status_out == ($past(status_out) | ($past(irq_raise) & $past(mask_out)))));

  a_r8_winner_below_ceiling: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (status_out[win_idx]
                   && ({1'b0, prio_flat[win_idx*PRIO_W +: PRIO_W]} < cur_q)));

  a_r10_lock_hides_winner: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> !win_valid);

  a_r10_locked_quiet: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !hard_raise && !cmd_valid) |=> !cpu_wake);

  a_r11_raise_wakes: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && (irq_raise != '0)) |=> cpu_wake);

  a_r12_hard_wakes: assert property (@(posedge clk) disable iff (rst)
    hard_raise |=> cpu_wake);
endmodule

bind irqc_top irqc_checker #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .irq_raise(irq_raise), .hard_raise(hard_raise),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cpu_wake(cpu_wake),
  .win_valid(win_valid), .win_idx(win_idx), .status_out(status_out),
  .mask_out(mask_out), .lock_q(lock_q), .cur_q(cur_q), .prio_flat(prio_flat)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int N  = 8;
  localparam int PW = 8;
  localparam int IW = 3;
  localparam int NV = 34;

  typedef struct packed {
    logic [7:0] raise;
    logic       hard;
    logic       cv;
    logic [2:0] op;
    logic [2:0] idx;
    logic [8:0] data;
    logic       e_wake;
    logic       e_valid;
    logic [2:0] e_idx;
    logic [7:0] e_st;
    logic [7:0] e_mask;
  } vec_t;

  // ops: 0 en, 1 dis, 2 clr, 3 clr-all, 4 clr-enabled, 5 prio, 6 ceiling, 7 lock
  localparam vec_t VECS [NV] = '{
    '{8'h04,1'b0,1'b0,3'd0,3'd0,9'd0,   1'b1,1'b0,3'd0,8'h00,8'h00}, // R11 masked raise wakes
    '{8'h00,1'b0,1'b0,3'd0,3'd0,9'd0,   1'b0,1'b0,3'd0,8'h00,8'h00}, // R11 pulse ends
    '{8'h00,1'b0,1'b1,3'd0,3'd2,9'd0,   1'b1,1'b1,3'd2,8'h04,8'h04}, // R4 enable latched line
    '{8'h00,1'b0,1'b1,3'd5,3'd5,9'd10,  1'b0,1'b1,3'd2,8'h04,8'h04}, // R2 priority write
    '{8'h00,1'b0,1'b1,3'd0,3'd5,9'd0,   1'b0,1'b1,3'd2,8'h04,8'h24}, // R3 enable, nothing latched
    '{8'h20,1'b0,1'b0,3'd0,3'd0,9'd0,   1'b1,1'b1,3'd5,8'h24,8'h24}, // R8 more urgent wins
    '{8'h00,1'b0,1'b1,3'd5,3'd2,9'd10,  1'b0,1'b1,3'd2,8'h24,8'h24}, // R9 tie to lower index
    '{8'h00,1'b0,1'b1,3'd6,3'd0,9'd10,  1'b0,1'b0,3'd0,8'h24,8'h24}, // R8 equal to ceiling loses
    '{8'h00,1'b0,1'b1,3'd6,3'd0,9'd11,  1'b0,1'b1,3'd2,8'h24,8'h24}, // R8 below ceiling
    '{8'h00,1'b0,1'b1,3'd6,3'd0,9'd256, 1'b0,1'b1,3'd2,8'h24,8'h24}, // R8 idle ceiling
    '{8'h00,1'b0,1'b1,3'd7,3'd0,9'd1,   1'b0,1'b0,3'd0,8'h24,8'h24}, // R10 lock hides winner
    '{8'h01,1'b0,1'b0,3'd0,3'd0,9'd0,   1'b0,1'b0,3'd0,8'h24,8'h24}, // R10 locked raise silent
    '{8'h00,1'b1,1'b0,3'd0,3'd0,9'd0,   1'b1,1'b0,3'd0,8'h24,8'h24}, // R12 hard bypasses lock
    '{8'h01,1'b0,1'b0,3'd0,3'd0,9'd0,   1'b0,1'b0,3'd0,8'h24,8'h24}, // R12 lock still held
    '{8'h00,1'b0,1'b1,3'd7,3'd0,9'd0,   1'b1,1'b1,3'd2,8'h24,8'h24}, // R10 unlock with status
    '{8'h00,1'b0,1'b1,3'd1,3'd2,9'd0,   1'b0,1'b1,3'd2,8'h24,8'h20}, // R5 disable keeps status
    '{8'h00,1'b0,1'b1,3'd2,3'd2,9'd0,   1'b0,1'b1,3'd5,8'h20,8'h20}, // R6 clear one
    '{8'h20,1'b0,1'b1,3'd2,3'd5,9'd0,   1'b1,1'b1,3'd5,8'h20,8'h20}, // R6 raise beats clear
    '{8'h00,1'b0,1'b1,3'd0,3'd0,9'd0,   1'b1,1'b1,3'd5,8'h21,8'h21}, // R4 latched while locked
    '{8'h00,1'b0,1'b1,3'd4,3'd0,9'd0,   1'b0,1'b0,3'd0,8'h00,8'h21}, // R7 clear enabled
    '{8'h08,1'b0,1'b0,3'd0,3'd0,9'd0,   1'b1,1'b0,3'd0,8'h00,8'h21}, // R11 masked raise
    '{8'h00,1'b0,1'b1,3'd4,3'd0,9'd0,   1'b0,1'b0,3'd0,8'h00,8'h21}, // R7 masked latch kept
    '{8'h00,1'b0,1'b1,3'd0,3'd3,9'd0,   1'b1,1'b1,3'd3,8'h08,8'h29}, // R7 kept latch surfaces
    '{8'h00,1'b0,1'b1,3'd3,3'd0,9'd0,   1'b0,1'b0,3'd0,8'h00,8'h29}, // R7 clear all
    '{8'h00,1'b0,1'b1,3'd1,3'd3,9'd0,   1'b0,1'b0,3'd0,8'h00,8'h21}, // R5 disable
    '{8'h00,1'b0,1'b1,3'd0,3'd3,9'd0,   1'b0,1'b0,3'd0,8'h00,8'h29}, // R7 latch gone after clear all
    '{8'h80,1'b0,1'b0,3'd0,3'd0,9'd0,   1'b1,1'b0,3'd0,8'h00,8'h29}, // R11 masked raise
    '{8'h09,1'b0,1'b0,3'd0,3'd0,9'd0,   1'b1,1'b1,3'd0,8'h09,8'h29}, // R9 tie at 255
    '{8'h00,1'b0,1'b1,3'd7,3'd0,9'd1,   1'b0,1'b0,3'd0,8'h09,8'h29}, // R10 lock
    '{8'h00,1'b0,1'b1,3'd0,3'd7,9'd0,   1'b0,1'b0,3'd0,8'h89,8'hA9}, // R10 locked enable silent
    '{8'h00,1'b0,1'b1,3'd7,3'd0,9'd0,   1'b1,1'b1,3'd0,8'h89,8'hA9}, // R10 unlock wakes
    '{8'h00,1'b0,1'b1,3'd3,3'd0,9'd0,   1'b0,1'b0,3'd0,8'h00,8'hA9}, // R7 clear all
    '{8'h00,1'b0,1'b1,3'd7,3'd0,9'd1,   1'b0,1'b0,3'd0,8'h00,8'hA9}, // R10 lock
    '{8'h00,1'b0,1'b1,3'd7,3'd0,9'd0,   1'b0,1'b0,3'd0,8'h00,8'hA9}  // R10 unlock, empty: no wake
  };
  localparam int REQ [NV] = '{11,11,4,2,3,8,9,8,8,8,10,10,12,12,10,5,6,6,4,7,
                              11,7,7,7,5,7,11,9,10,10,10,7,10,10};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_raise = '0;
  logic          hard_raise = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [IW-1:0] cmd_idx = '0;
  logic [PW:0]   cmd_data = '0;
  logic          cpu_wake, win_valid;
  logic [IW-1:0] win_idx;
  logic [N-1:0]  status_out, mask_out;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  irqc_top #(.N_IRQ(N), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst(rst), .irq_raise(irq_raise), .hard_raise(hard_raise),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .cpu_wake(cpu_wake), .win_valid(win_valid), .win_idx(win_idx),
    .status_out(status_out), .mask_out(mask_out)
  );

  task automatic step(input logic [7:0] r, input logic h, input logic cv,
                      input logic [2:0] op, input logic [2:0] ix, input logic [8:0] d);
    irq_raise  = r;
    hard_raise = h;
    cmd_valid  = cv;
    cmd_op     = op;
    cmd_idx    = ix;
    cmd_data   = d;
    @(posedge clk);
    @(negedge clk);
    irq_raise  = '0;
    hard_raise = 1'b0;
    cmd_valid  = 1'b0;
  endtask

  task automatic check(input string req, input logic w, input logic v,
                       input logic [2:0] ix, input logic [7:0] st, input logic [7:0] m);
    n_chk++;
    if (cpu_wake !== w || win_valid !== v || win_idx !== ix
        || status_out !== st || mask_out !== m) begin
      n_fail++;
      $display("FAIL %s: got wake=%b valid=%b idx=%0d st=%h mask=%h, expected wake=%b valid=%b idx=%0d st=%h mask=%h",
               req, cpu_wake, win_valid, win_idx, status_out, mask_out, w, v, ix, st, m);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 3'd0, 8'h00, 8'h00);

    for (int k = 0; k < NV; k++) begin
      step(VECS[k].raise, VECS[k].hard, VECS[k].cv, VECS[k].op, VECS[k].idx, VECS[k].data);
      check($sformatf("R%0d vec%0d", REQ[k], k), VECS[k].e_wake, VECS[k].e_valid,
            VECS[k].e_idx, VECS[k].e_st, VECS[k].e_mask);
    end

    // R1: mid-run reset restores mask, records, lock, ceiling and priorities
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 after reset", 1'b0, 1'b0, 3'd0, 8'h00, 8'h00);
    step(8'h00, 1'b0, 1'b1, 3'd0, 3'd1, 9'd0);
    check("R1 latch cleared", 1'b0, 1'b0, 3'd0, 8'h00, 8'h02);
    step(8'h02, 1'b0, 1'b0, 3'd0, 3'd0, 9'd0);
    check("R1 ceiling idle", 1'b1, 1'b1, 3'd1, 8'h02, 8'h02);
    step(8'h00, 1'b0, 1'b1, 3'd6, 3'd0, 9'd255);
    check("R1 priority back to 255", 1'b0, 1'b0, 3'd0, 8'h02, 8'h02);
    step(8'h00, 1'b0, 1'b1, 3'd7, 3'd0, 9'd1);
    step(8'h00, 1'b1, 1'b0, 3'd0, 3'd0, 9'd0);
    check("R12 hard under lock", 1'b1, 1'b0, 3'd0, 8'h02, 8'h02);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule